// File: doc/BRIEF.md
# Clock ratio estimator

This block is an all-digital tracking loop. It measures how fast an incoming sample stream runs compared with a local output sample clock, and it reports the result as a frequency tuning word (FTW). The FTW is an unsigned fixed-point ratio, input samples per output sample, with `FRAC` fractional bits. A phase accumulator adds the FTW once per output sample. Its integer part and its fraction together select the phase of a downstream interpolation filter.

Both word clocks are sampled by the fast reference clock. The loop does not react to single clock periods. It waits for a window of `2^WIN_LOG2` input periods, and only then compares the input samples that really arrived with the phase the accumulator consumed over the same span. The error from that window feeds a proportional-plus-integral servo on the accumulated phase error, with power-of-two gains. The result is a second-order low-pass loop. It updates once per window, so its corner frequency is a fixed fraction of the sample rate. Small gains make the FTW creep toward the true ratio. Slow drift is followed, and clock jitter within a window is averaged away.

A lock flag uses hysteresis. If either word clock stops, the loop freezes its estimate and drops lock.

Top module: `clk_ratio_est`

## Requirements
- R1: In reset, `ftw` equals `1 << FRAC` (ratio 1.0), the phase outputs are zero and `locked` is low.
- R2: On each rising edge of the output word clock, the current `ftw` is added to the accumulator `{phase_int, phase_frac}`. At all other times the accumulator does not change. `phase_int` holds the upper `IW` bits and `phase_frac` the lower `FRAC` bits.
- R3: `ftw` changes only when a measurement window closes. A window spans `2^WIN_LOG2` rising edges of the input word clock. Counting starts at the first such edge after reset or after a stall, so two changes are always at least `2^WIN_LOG2` input periods apart.
- R4: The window error is `2^WIN_LOG2 << FRAC` minus the accumulator advance over that window. This error is added to a running phase error. The FTW then moves by `(window error >>> kp_shift) + (running error >>> ki_shift)`, using arithmetic shifts. A zero error leaves `ftw` unchanged, and a positive error raises it.
- R5: With steady clocks, `ftw` settles within 1/32 of `(f_in / f_out) << FRAC` for ratios from 0.75 to 1.5. This holds with a 32-period window, `kp_shift` = 7 and `ki_shift` = 11.
- R6: The FTW update saturates to the range 1 to `2^FW - 1`, so `ftw` is never zero.
- R7: `locked` rises after `LOCK_IN` (16) consecutive windows whose running error has a magnitude below `lock_thresh`. It falls after `LOCK_OUT` (4) consecutive windows at or above `lock_thresh`.
- R8: If either word clock shows no rising edge for `TIMEOUT` reference cycles, four things happen. `locked` is cleared, `ftw` holds its value, the running error is cleared, and a new window starts at the next input edge once both clocks are present. Meanwhile the accumulator keeps stepping at output edges using the held FTW.
- R9: The accumulator wraps modulo `2^(IW+FRAC)`, and the window measurement stays correct across a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wclk | input | 1 | Input-side word clock, one period per incoming sample |
| out_wclk | input | 1 | Output-side word clock, one period per output sample |
| kp_shift | input | 5 | Right-shift applied to the window error (proportional gain) |
| ki_shift | input | 5 | Right-shift applied to the running phase error (integral gain) |
| lock_thresh | input | IW+FRAC | Lock band on the running phase error, in accumulator units |
| ftw | output | FW | Frequency tuning word, input samples per output sample, FRAC fractional bits |
| phase_int | output | IW | Integer part of the accumulated phase index |
| phase_frac | output | FRAC | Fractional part of the accumulated phase index |
| locked | output | 1 | Loop has stayed inside the lock band |

## Verification
The assertions check the cycle-level rules on every cycle:
- the accumulator moves only on an output edge;
- the FTW moves only at a window close and never reaches zero;
- lock changes only at a window close or a stall;
- a stall blocks updates and clears lock.

The bench scenarios show the behaviour that only builds up over many windows:
- convergence to several ratios;
- the exact timing of lock-in and of lock loss;
- the FTW held through missing clocks;
- saturation at the lower FTW limit under extreme gains;
- step-by-step agreement between the accumulator and the FTW across wraps.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int SW = 48;
  typedef logic signed [SW-1:0] sval_t;

  localparam sval_t SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam sval_t SMIN = {1'b1, {(SW-1){1'b0}}};

  // saturating signed sum
  function automatic sval_t sat_add(input sval_t a, input sval_t b);
    sval_t s;
    s = a + b;
    if ((a[SW-1] == b[SW-1]) && (s[SW-1] != a[SW-1]))
      s = a[SW-1] ? SMIN : SMAX;
    return s;
  endfunction

  // magnitude, saturating the most negative value
  function automatic sval_t mag(input sval_t a);
    if (a == SMIN) return SMAX;
    return a[SW-1] ? -a : a;
  endfunction

  // velocity-form PI: next word before clamping
  function automatic sval_t pi_step(input sval_t cur, input sval_t win_err,
                                    input sval_t acc_err, input logic [4:0] kp,
                                    input logic [4:0] ki);
    return cur + (win_err >>> kp) + (acc_err >>> ki);
  endfunction
endpackage

// File: rtl/cre_edge_mon.sv
module cre_edge_mon #(
  parameter int TIMEOUT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk,
  output logic evt,
  output logic miss
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] idle_q;

  assign evt  = sync_q[1] & ~sync_q[2];
  assign miss = (idle_q == CW'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      idle_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], wclk};
      if (evt)
        idle_q <= '0;
      else if (!miss)
        idle_q <= idle_q + CW'(1);
    end
  end

  // R8
  edge_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !miss);
endmodule

// File: rtl/cre_window.sv
module cre_window import cre_pkg::*; #(
  parameter int WIN_LOG2 = 12,
  parameter int FRAC     = 24,
  parameter int PW       = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_evt,
  input  logic          stall,
  input  logic [PW-1:0] phase,
  output logic          upd,
  output sval_t         win_err
);
  localparam logic [PW-1:0] NOMINAL = PW'(64'd1 << (WIN_LOG2 + FRAC));

  logic                armed_q;
  logic [WIN_LOG2-1:0] cnt_q;
  logic [PW-1:0]       start_q;
  logic [PW-1:0]       advance;
  logic                closing;

  assign closing = armed_q & in_evt & (cnt_q == '1);
  assign upd     = closing & ~stall;
  assign advance = phase - start_q;   // modulo: survives accumulator wrap
  assign win_err = sval_t'({{(SW-PW){1'b0}}, NOMINAL}) - sval_t'({{(SW-PW){1'b0}}, advance});

  always_ff @(posedge clk) begin
    if (!rst_n || stall) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      start_q <= '0;
    end else if (in_evt) begin
      if (!armed_q) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        start_q <= phase;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '1) start_q <= phase;
      end
    end
  end

  // R8
  stall_blocks_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !upd);
endmodule

// File: rtl/cre_loop.sv
module cre_loop import cre_pkg::*; #(
  parameter int            FW       = 32,
  parameter int            PW       = 40,
  parameter logic [FW-1:0] FTW_INIT = FW'(1),
  parameter int            LOCK_IN  = 16,
  parameter int            LOCK_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          stall,
  input  sval_t         win_err,
  input  logic [4:0]    kp_shift,
  input  logic [4:0]    ki_shift,
  input  logic [PW-1:0] lock_thresh,
  output logic [FW-1:0] ftw,
  output logic          locked
);
  localparam int    GW      = $clog2(LOCK_IN + 1);
  localparam int    BW      = $clog2(LOCK_OUT + 1);
  localparam sval_t FTW_TOP = sval_t'((64'd1 << FW) - 64'd1);

  sval_t         perr_q, perr_nx, step_nx, clamp_nx;
  logic [FW-1:0] ftw_nx;
  logic          in_band;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_comb begin
    perr_nx = sat_add(perr_q, win_err);
    step_nx = pi_step(sval_t'({{(SW-FW){1'b0}}, ftw}), win_err, perr_nx, kp_shift, ki_shift);
    if (step_nx < sval_t'(1))
      clamp_nx = sval_t'(1);
    else if (step_nx > FTW_TOP)
      clamp_nx = FTW_TOP;
    else
      clamp_nx = step_nx;
    ftw_nx  = clamp_nx[FW-1:0];
    in_band = mag(perr_nx) < sval_t'({{(SW-PW){1'b0}}, lock_thresh});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw    <= FTW_INIT;
      perr_q <= '0;
      good_q <= '0;
      bad_q  <= '0;
      locked <= 1'b0;
    end else if (stall) begin
      perr_q <= '0;
      good_q <= '0;
      bad_q  <= '0;
      locked <= 1'b0;
    end else if (upd) begin
      perr_q <= perr_nx;
      ftw    <= ftw_nx;
      if (in_band) begin
        bad_q <= '0;
        if (good_q != GW'(LOCK_IN)) good_q <= good_q + 1'b1;
        if (good_q == GW'(LOCK_IN - 1)) locked <= 1'b1;
      end else begin
        good_q <= '0;
        if (bad_q != BW'(LOCK_OUT)) bad_q <= bad_q + 1'b1;
        if (bad_q == BW'(LOCK_OUT - 1)) locked <= 1'b0;
      end
    end
  end

  // R3
  ftw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ftw));
  // R6
  ftw_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ftw != '0);
  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(upd));
  // R7
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(upd) || $past(stall)));
  // R8
  stall_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !locked);
endmodule

// File: rtl/cre_phase_acc.sv
module cre_phase_acc #(
  parameter int FW = 32,
  parameter int PW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_evt,
  input  logic [FW-1:0] ftw,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (out_evt)
      phase <= phase + PW'(ftw);   // wraps modulo 2^PW
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_evt |=> $stable(phase));
endmodule

// File: rtl/clk_ratio_est.sv
module clk_ratio_est import cre_pkg::*; #(
  parameter int FW       = 32,
  parameter int FRAC     = 24,
  parameter int IW       = 16,
  parameter int WIN_LOG2 = 12,
  parameter int TIMEOUT  = 65536,
  parameter int LOCK_IN  = 16,
  parameter int LOCK_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_wclk,
  input  logic               out_wclk,
  input  logic [4:0]         kp_shift,
  input  logic [4:0]         ki_shift,
  input  logic [IW+FRAC-1:0] lock_thresh,
  output logic [FW-1:0]      ftw,
  output logic [IW-1:0]      phase_int,
  output logic [FRAC-1:0]    phase_frac,
  output logic               locked
);
  localparam int            PW      = IW + FRAC;
  localparam logic [FW-1:0] FTW_ONE = FW'(64'd1 << FRAC);

  logic [1:0]    wclk_vec, evt_vec, miss_vec;
  logic          in_evt, out_evt, stall, upd_evt;
  sval_t         win_err;
  logic [PW-1:0] phase;

  assign wclk_vec = {out_wclk, in_wclk};

  for (genvar g = 0; g < 2; g++) begin : g_mon
    cre_edge_mon #(.TIMEOUT(TIMEOUT)) u_mon (
      .clk  (clk),
      .rst_n(rst_n),
      .wclk (wclk_vec[g]),
      .evt  (evt_vec[g]),
      .miss (miss_vec[g])
    );
  end

  assign in_evt  = evt_vec[0];
  assign out_evt = evt_vec[1];
  assign stall   = |miss_vec;

  cre_window #(.WIN_LOG2(WIN_LOG2), .FRAC(FRAC), .PW(PW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_evt (in_evt),
    .stall  (stall),
    .phase  (phase),
    .upd    (upd_evt),
    .win_err(win_err)
  );

  cre_loop #(.FW(FW), .PW(PW), .FTW_INIT(FTW_ONE), .LOCK_IN(LOCK_IN),
             .LOCK_OUT(LOCK_OUT)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (upd_evt),
    .stall      (stall),
    .win_err    (win_err),
    .kp_shift   (kp_shift),
    .ki_shift   (ki_shift),
    .lock_thresh(lock_thresh),
    .ftw        (ftw),
    .locked     (locked)
  );

  cre_phase_acc #(.FW(FW), .PW(PW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .out_evt(out_evt),
    .ftw    (ftw),
    .phase  (phase)
  );

  assign phase_int  = phase[PW-1:FRAC];
  assign phase_frac = phase[FRAC-1:0];
endmodule

// File: tb/sim_clk_ratio_est.sv
module sim_clk_ratio_est;
  localparam int FW = 32, FRAC = 24, IW = 12, PW = IW + FRAC;
  localparam longint ONE = 64'd1 << FRAC;

  typedef struct packed {
    int unsigned pin;
    int unsigned pout;
    int unsigned exp;
  } vec_t;

  // in period, out period (reference cycles), expected ftw = pout/pin << 24
  localparam vec_t VEC [5] = '{
    '{12, 12, 16777216},
    '{12, 15, 20971520},
    '{12,  9, 12582912},
    '{10, 15, 25165824},
    '{12, 10, 13981013}
  };

  logic clk = 1'b0;
  logic rst_n, in_wclk = 1'b0, out_wclk = 1'b0, locked;
  logic [4:0] kp_shift, ki_shift;
  logic [PW-1:0] lock_thresh;
  logic [FW-1:0] ftw;
  logic [IW-1:0] phase_int;
  logic [FRAC-1:0] phase_frac;

  always #4 clk = ~clk;

  clk_ratio_est #(.FW(FW), .FRAC(FRAC), .IW(IW), .WIN_LOG2(5), .TIMEOUT(64),
                  .LOCK_IN(16), .LOCK_OUT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_wclk(in_wclk), .out_wclk(out_wclk),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .lock_thresh(lock_thresh),
    .ftw(ftw), .phase_int(phase_int), .phase_frac(phase_frac), .locked(locked));

  int n_chk = 0, n_err = 0;
  int in_per = 12, out_per = 12, in_c = 0, out_c = 0;
  bit in_en = 0, out_en = 0, mon_on = 0, track_min = 0, seen_chg = 0;
  int cyc = 0, last_chg = 0, min_gap = 1000000000;
  int ph_steps = 0, ph_bad = 0, ph_wraps = 0;
  logic [PW-1:0] prev_ph = '0, cur_ph;
  logic [FW-1:0] prev_ftw = '0, ftw_min = '1;

  // word clock generators, driven away from the active edge
  always @(negedge clk) begin
    if (in_en) begin
      in_c = (in_c + 1 >= in_per) ? 0 : in_c + 1;
      in_wclk <= (in_c < in_per / 2);
    end else in_wclk <= 1'b0;
    if (out_en) begin
      out_c = (out_c + 1 >= out_per) ? 0 : out_c + 1;
      out_wclk <= (out_c < out_per / 2);
    end else out_wclk <= 1'b0;
  end

  // output monitor: accumulator steps (R2, R9), update spacing (R3), minimum ftw (R6)
  always @(negedge clk) begin
    cyc = cyc + 1;
    cur_ph = {phase_int, phase_frac};
    if (mon_on) begin
      if (cur_ph != prev_ph) begin
        ph_steps++;
        if (cur_ph != prev_ph + PW'(prev_ftw)) ph_bad++;
        if (cur_ph < prev_ph) ph_wraps++;
      end
      if (ftw != prev_ftw) begin
        if (seen_chg && (cyc - last_chg) < min_gap) min_gap = cyc - last_chg;
        seen_chg = 1;
        last_chg = cyc;
      end
      if (track_min && ftw < ftw_min) ftw_min = ftw;
    end
    prev_ph = cur_ph;
    prev_ftw = ftw;
  end

  task automatic chk(input string req, input string what, input longint act,
                     input longint exp, input bit ok);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk("WD", "watchdog expired", 0, 1, 1'b0);
    finish_run();
  end

  initial begin
    longint f0, diff, p0;
    rst_n = 1'b0;
    kp_shift = 5'd7;
    ki_shift = 5'd11;
    lock_thresh = PW'(64'd1 << 27);
    wait_cyc(5);
    // R1 reset state
    chk("R1", "ftw in reset", ftw, ONE, ftw == FW'(ONE));
    chk("R1", "phase in reset", {phase_int, phase_frac}, 0, {phase_int, phase_frac} == '0);
    chk("R1", "locked in reset", locked, 0, locked == 1'b0);
    rst_n = 1'b1;
    in_en = 1;
    out_en = 1;
    mon_on = 1;

    // R7 lock-in timing with equal rates: 16 windows of 32*12 cycles
    wait_cyc(5760);
    chk("R7", "no lock before 16 windows", locked, 0, locked == 1'b0);
    wait_cyc(784);
    chk("R7", "lock after 16 windows", locked, 1, locked == 1'b1);
    chk("R4", "zero error keeps ftw", ftw, ONE, ftw == FW'(ONE));

    // R5 table of ratios
    for (int i = 0; i < 5; i++) begin
      in_per = VEC[i].pin;
      out_per = VEC[i].pout;
      wait_cyc(22000);
      diff = (longint'(ftw) > longint'(VEC[i].exp)) ? longint'(ftw) - VEC[i].exp
                                                   : longint'(VEC[i].exp) - ftw;
      chk("R5", "ftw settles to ratio", ftw, VEC[i].exp, diff <= longint'(VEC[i].exp) / 32);
      chk("R7", "locked after settling", locked, 1, locked == 1'b1);
    end

    // R7 loss of lock after a ratio jump 0.833 -> 1.25
    out_per = 15;
    f0 = ftw;
    wait_cyc(768);
    chk("R7", "lock held under 4 bad windows", locked, 1, locked == 1'b1);
    wait_cyc(3840);
    chk("R7", "lock lost after bad windows", locked, 0, locked == 1'b0);
    chk("R4", "positive error raises ftw", ftw, f0, longint'(ftw) > f0);

    // R8 input word clock stops
    in_en = 0;
    wait_cyc(100);
    f0 = ftw;
    wait_cyc(2000);
    chk("R8", "ftw held without input clock", ftw, f0, longint'(ftw) == f0);
    chk("R8", "unlocked without input clock", locked, 0, locked == 1'b0);
    in_en = 1;
    wait_cyc(22000);
    chk("R8", "relock after input returns", locked, 1, locked == 1'b1);

    // R8 output word clock stops: ftw and phase frozen
    out_en = 0;
    wait_cyc(100);
    f0 = ftw;
    p0 = {phase_int, phase_frac};
    wait_cyc(2000);
    chk("R8", "ftw held without output clock", ftw, f0, longint'(ftw) == f0);
    chk("R8", "unlocked without output clock", locked, 0, locked == 1'b0);
    chk("R2", "phase still without output edges", {phase_int, phase_frac}, p0,
        longint'({phase_int, phase_frac}) == p0);

    // R6 extreme gains force the lower clamp
    kp_shift = 5'd0;
    ki_shift = 5'd0;
    out_per = 12;
    out_en = 1;
    track_min = 1;
    wait_cyc(3000);
    chk("R6", "ftw clamps at 1", ftw_min, 1, ftw_min == FW'(1));

    chk("R2", "phase steps equal ftw", ph_bad, 0, ph_bad == 0 && ph_steps > 0);
    chk("R9", "accumulator wrapped", ph_wraps, 1, ph_wraps > 0);
    chk("R3", "min cycles between ftw changes", min_gap, 300, seen_chg && min_gap >= 300);
    finish_run();
  end
endmodule